// File: doc/BRIEF.md
# Audio Codec Link Output Frame Serializer

This block turns a small set of parallel inputs into the serial output stream of an AC97 audio codec link. It runs entirely on the bit clock that the codec supplies. Every 256 bit periods it sends one complete frame on a single data line, most significant bit of each field first. The frame opens with a 16-bit tag that marks which slots carry valid content. Next come a command-address slot and a command-data slot, then a left and a right PCM slot. The rest of the frame is zero padding. A frame strobe tells the codec where each frame begins.

Both PCM slots carry the same sample. It is one of two fixed signed levels, chosen by a one-bit square-wave input, so a tone source elsewhere in the chip can drive the codec with no sample path of its own. The command slots carry whatever words the caller presents, for example a register write issued again in every frame. The square-wave level, both command words and their valid flags are captured once per frame, at the moment the frame is loaded, so one frame never mixes old and new values.

A field sequencer walks six named states, one for each field on the line: ST_TAG (bits 0 to 15), ST_ADDR (16 to 35), ST_DATA (36 to 55), ST_LEFT (56 to 75), ST_RIGHT (76 to 95) and ST_PAD (96 to 255). An 8-bit bit counter drives the transitions. The sequencer moves from ST_TAG to ST_ADDR after bit 15, from ST_ADDR to ST_DATA after bit 35, from ST_DATA to ST_LEFT after bit 55, from ST_LEFT to ST_RIGHT after bit 75, and from ST_RIGHT to ST_PAD after bit 95. It moves from ST_PAD back to ST_TAG when the counter wraps after bit 255. On every transition a 20-bit field shift register is reloaded with the next field's content.

Top module: `ac97_frame_tx`

## Requirements
- R1: A new frame starts every 256 bit clocks. The strobe rises exactly 256 bit clocks after its previous rise.
- R2: Every field is sent most significant bit first. Frame bit 0 is tag bit 15, and bit 16 is slot 1 bit 19.
- R3: The strobe is high for exactly 16 bit periods. It rises during the last bit (255) of the previous frame and falls when the last tag bit (frame bit 15) goes out.
- R4: Tag bit 15 is 1. Bit 14 equals the address flag and bit 13 equals the data flag. Bits 12 and 11 are 1. Bits 10 down to 0 are 0.
- R5: Slot 1 (frame bits 16 to 35) carries the 20-bit address word when its flag is 1, and all zeros when it is 0. Slot 2 (bits 36 to 55) follows the same rule with the data word and data flag.
- R6: Slots 3 and 4 (bits 56 to 95) each carry 20'h3D090 (+250000) when the square-wave input is 1, and 20'hC2F70 (-250000, two's complement) when it is 0.
- R7: Frame bits 96 to 255 (slots 5 to 12) are all 0.
- R8: The inputs are captured only at the bit-clock edge that places frame bit 0 on the line. A change during a frame does not affect that frame and first appears in the next one.
- R9: Both outputs change only on the rising bit-clock edge and have defined values from time zero. Before the first edge, the strobe is 1 and the data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock supplied by the codec |
| tone_i | input | 1 | Square-wave level that selects the PCM sample |
| cmd_addr_i | input | 20 | Command-address slot word |
| cmd_addr_vld_i | input | 1 | Address slot valid flag |
| cmd_data_i | input | 20 | Command-data slot word |
| cmd_data_vld_i | input | 1 | Data slot valid flag |
| sdata_o | output | 1 | Serial frame data, sampled by the codec on the falling edge |
| sync_o | output | 1 | Frame strobe |

## Verification
The assertions check the bit counter's single step and wrap on every cycle. They also check that the strobe rises only on bit 255 and always stays high for exactly 16 bits, that the frame-valid bit is 1, that tag bits 10 to 0 and the whole pad region are 0, and that the captured square-wave level holds still between frame loads. Only the bench scenarios can show that each field carries the right content for a given set of inputs. That covers the valid flags masking the command words, the two PCM levels, most-significant-bit-first order across whole slots, and a square-wave change made in mid-frame showing up one frame late.

// File: rtl/ac97_tx_pkg.sv
package ac97_tx_pkg;
    typedef enum logic [2:0] {
        ST_TAG   = 3'd0,
        ST_ADDR  = 3'd1,
        ST_DATA  = 3'd2,
        ST_LEFT  = 3'd3,
        ST_RIGHT = 3'd4,
        ST_PAD   = 3'd5
    } field_e;
endpackage

// File: rtl/ac97_tx_seq.sv
module ac97_tx_seq
    import ac97_tx_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int TAG_BITS   = 16,
    parameter int SLOT_BITS  = 20,
    parameter int CW         = $clog2(FRAME_BITS)
) (
    input  logic          bit_clk,
    output logic [CW-1:0] cnt_o,
    output field_e        state_o,
    output field_e        state_nx_o,
    output logic          field_end_o,
    output logic          frame_end_o,
    output logic          sync_o
);
    localparam logic [CW-1:0] E_LAST  = CW'(FRAME_BITS - 1);
    localparam logic [CW-1:0] E_TAG   = CW'(TAG_BITS - 1);
    localparam logic [CW-1:0] E_ADDR  = CW'(TAG_BITS - 1 + SLOT_BITS);
    localparam logic [CW-1:0] E_DATA  = CW'(TAG_BITS - 1 + 2 * SLOT_BITS);
    localparam logic [CW-1:0] E_LEFT  = CW'(TAG_BITS - 1 + 3 * SLOT_BITS);
    localparam logic [CW-1:0] E_RIGHT = CW'(TAG_BITS - 1 + 4 * SLOT_BITS);

    logic [CW-1:0] cnt_q    = E_LAST;
    field_e        state_q  = ST_PAD;
    logic          sync_q   = 1'b1;
    logic [CW-1:0] cnt_nx;
    field_e        state_nx;

    // State register process
    always_ff @(posedge bit_clk) begin
        cnt_q   <= cnt_nx;
        state_q <= state_nx;
        sync_q  <= (cnt_nx == E_LAST) || (cnt_nx < E_TAG);
    end

    // Next state: one transition per field boundary
    always_comb begin
        cnt_nx   = (cnt_q == E_LAST) ? '0 : cnt_q + 1'b1;
        state_nx = state_q;
        unique case (state_q)
            ST_TAG:   if (cnt_q == E_TAG)   state_nx = ST_ADDR;
            ST_ADDR:  if (cnt_q == E_ADDR)  state_nx = ST_DATA;
            ST_DATA:  if (cnt_q == E_DATA)  state_nx = ST_LEFT;
            ST_LEFT:  if (cnt_q == E_LEFT)  state_nx = ST_RIGHT;
            ST_RIGHT: if (cnt_q == E_RIGHT) state_nx = ST_PAD;
            ST_PAD:   if (cnt_q == E_LAST)  state_nx = ST_TAG;
            default:  state_nx = ST_PAD;
        endcase
    end

    // Outputs
    always_comb begin
        cnt_o       = cnt_q;
        state_o     = state_q;
        state_nx_o  = state_nx;
        field_end_o = (state_nx != state_q);
        frame_end_o = (cnt_q == E_LAST);
        sync_o      = sync_q;
    end
endmodule

// File: rtl/ac97_tx_fieldsel.sv
module ac97_tx_fieldsel
    import ac97_tx_pkg::*;
#(
    parameter int TAG_BITS  = 16,
    parameter int SLOT_BITS = 20,
    parameter int PCM_LEVEL = 250000
) (
    input  field_e               sel_i,
    input  logic                 tone_i,
    input  logic                 addr_vld_i,
    input  logic                 data_vld_i,
    input  logic [SLOT_BITS-1:0] addr_i,
    input  logic [SLOT_BITS-1:0] data_i,
    output logic [SLOT_BITS-1:0] word_o
);
    localparam logic [SLOT_BITS-1:0] PCM_POS = SLOT_BITS'(PCM_LEVEL);
    localparam logic [SLOT_BITS-1:0] PCM_NEG = SLOT_BITS'(-PCM_LEVEL);

    logic [TAG_BITS-1:0] tag;

    always_comb begin
        tag                 = '0;
        tag[TAG_BITS-1]     = 1'b1;
        tag[TAG_BITS-2]     = addr_vld_i;
        tag[TAG_BITS-3]     = data_vld_i;
        tag[TAG_BITS-4]     = 1'b1;
        tag[TAG_BITS-5]     = 1'b1;
        unique case (sel_i)
            ST_TAG:            word_o = {tag, {(SLOT_BITS - TAG_BITS){1'b0}}};
            ST_ADDR:           word_o = addr_vld_i ? addr_i : '0;
            ST_DATA:           word_o = data_vld_i ? data_i : '0;
            ST_LEFT, ST_RIGHT: word_o = tone_i ? PCM_POS : PCM_NEG;
            ST_PAD:            word_o = '0;
            default:           word_o = '0;
        endcase
    end
endmodule

// File: rtl/ac97_frame_tx.sv
module ac97_frame_tx
    import ac97_tx_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int TAG_BITS   = 16,
    parameter int SLOT_BITS  = 20,
    parameter int PCM_LEVEL  = 250000
) (
    input  logic                 bit_clk,
    input  logic                 tone_i,
    input  logic [SLOT_BITS-1:0] cmd_addr_i,
    input  logic                 cmd_addr_vld_i,
    input  logic [SLOT_BITS-1:0] cmd_data_i,
    input  logic                 cmd_data_vld_i,
    output logic                 sdata_o,
    output logic                 sync_o
);
    localparam int CW = $clog2(FRAME_BITS);

    logic [CW-1:0]        cnt;
    field_e               state;
    field_e               state_nx;
    logic                 field_end;
    logic                 frame_end;

    // Per-frame capture of the inputs
    logic                 snap_sq = 1'b0;
    logic                 snap_av = 1'b0;
    logic                 snap_dv = 1'b0;
    logic [SLOT_BITS-1:0] snap_aw = '0;
    logic [SLOT_BITS-1:0] snap_dw = '0;
    logic [SLOT_BITS-1:0] fld_q   = '0;
    logic [SLOT_BITS-1:0] next_word;
    logic                 sel_sq, sel_av, sel_dv;

    ac97_tx_seq #(
        .FRAME_BITS(FRAME_BITS), .TAG_BITS(TAG_BITS),
        .SLOT_BITS(SLOT_BITS),   .CW(CW)
    ) u_seq (
        .bit_clk    (bit_clk),
        .cnt_o      (cnt),
        .state_o    (state),
        .state_nx_o (state_nx),
        .field_end_o(field_end),
        .frame_end_o(frame_end),
        .sync_o     (sync_o)
    );

    // The tag is loaded on the same edge the capture happens, so take live inputs then
    always_comb begin
        sel_sq = frame_end ? tone_i         : snap_sq;
        sel_av = frame_end ? cmd_addr_vld_i : snap_av;
        sel_dv = frame_end ? cmd_data_vld_i : snap_dv;
    end

    ac97_tx_fieldsel #(
        .TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS), .PCM_LEVEL(PCM_LEVEL)
    ) u_sel (
        .sel_i     (state_nx),
        .tone_i    (sel_sq),
        .addr_vld_i(sel_av),
        .data_vld_i(sel_dv),
        .addr_i    (snap_aw),
        .data_i    (snap_dw),
        .word_o    (next_word)
    );

    always_ff @(posedge bit_clk) begin
        if (frame_end) begin
            snap_sq <= tone_i;
            snap_av <= cmd_addr_vld_i;
            snap_dv <= cmd_data_vld_i;
            snap_aw <= cmd_addr_i;
            snap_dw <= cmd_data_i;
        end
        fld_q <= field_end ? next_word : {fld_q[SLOT_BITS-2:0], 1'b0};
    end

    assign sdata_o = fld_q[SLOT_BITS-1];
endmodule

// File: rtl/ac97_frame_tx_chk.sv
module ac97_frame_tx_chk
    import ac97_tx_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int TAG_BITS   = 16,
    parameter int CW         = 8
) (
    input logic          bit_clk,
    input logic          sdata,
    input logic          sync,
    input logic [CW-1:0] cnt,
    input field_e        state,
    input logic          snap_sq
);
    localparam logic [CW-1:0] C_LAST = CW'(FRAME_BITS - 1);
    localparam logic [CW-1:0] C_TAGE = CW'(TAG_BITS - 1);

    logic       armed_q = 1'b0;
    logic [7:0] run_q   = '0;

    always_ff @(posedge bit_clk) begin
        armed_q <= 1'b1;
        run_q   <= sync ? run_q + 1'b1 : 8'd0;
    end

    p_count_step_r1: assert property (@(posedge bit_clk) disable iff (!armed_q)
        cnt == (($past(cnt) == C_LAST) ? '0 : CW'($past(cnt) + 1'b1)));

    p_sync_rise_r3: assert property (@(posedge bit_clk) disable iff (!armed_q)
        $rose(sync) |-> cnt == C_LAST);

    p_sync_len_r3: assert property (@(posedge bit_clk) disable iff (!armed_q)
        $fell(sync) |-> run_q == 8'(TAG_BITS));

    p_frame_valid_r4: assert property (@(posedge bit_clk) disable iff (!armed_q)
        (cnt == '0) |-> sdata);

    p_tag_tail_r4: assert property (@(posedge bit_clk) disable iff (!armed_q)
        (cnt >= CW'(5) && cnt <= C_TAGE) |-> !sdata);

    p_pad_zero_r7: assert property (@(posedge bit_clk) disable iff (!armed_q)
        (state == ST_PAD) |-> !sdata);

    p_snap_hold_r8: assert property (@(posedge bit_clk) disable iff (!armed_q)
        (cnt != '0) |-> $stable(snap_sq));
endmodule

bind ac97_frame_tx ac97_frame_tx_chk #(
    .FRAME_BITS(FRAME_BITS), .TAG_BITS(TAG_BITS), .CW(CW)
) u_chk (
    .bit_clk(bit_clk),
    .sdata  (sdata_o),
    .sync   (sync_o),
    .cnt    (cnt),
    .state  (state),
    .snap_sq(snap_sq)
);

// File: tb/ac97_frame_tx_bench.sv
module ac97_frame_tx_bench;
    typedef struct packed {
        logic        sq;
        logic        av;
        logic        dv;
        logic [19:0] aw;
        logic [19:0] dw;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b1, 1'b1, 20'h02000, 20'h8A8A0},
        '{1'b0, 1'b1, 1'b1, 20'h04000, 20'h8F8F0},
        '{1'b1, 1'b1, 1'b0, 20'h98000, 20'hFFFFF},
        '{1'b0, 1'b0, 1'b0, 20'hFFFFF, 20'h12345},
        '{1'b0, 1'b0, 1'b1, 20'h00000, 20'hABCDE},
        '{1'b1, 1'b1, 1'b1, 20'hFFFFF, 20'hFFFFF}
    };
    localparam logic [19:0] PCM_HI = 20'h3D090;
    localparam logic [19:0] PCM_LO = 20'hC2F70;

    logic        clk = 1'b0;
    logic        sq  = 1'b0;
    logic        av  = 1'b0;
    logic        dv  = 1'b0;
    logic [19:0] aw  = '0;
    logic [19:0] dw  = '0;
    logic        sdata;
    logic        sync;

    int n_run  = 0;
    int n_fail = 0;
    logic [255:0] cap;
    logic [255:0] capsync;

    always #10 clk = ~clk;

    ac97_frame_tx u_ac97_frame_tx (
        .bit_clk       (clk),
        .tone_i        (sq),
        .cmd_addr_i    (aw),
        .cmd_addr_vld_i(av),
        .cmd_data_i    (dw),
        .cmd_data_vld_i(dv),
        .sdata_o       (sdata),
        .sync_o        (sync)
    );

    task automatic chk(input string req, input logic [159:0] act, input logic [159:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // Wait for a strobe rise (frame bit 255 on the line), then take the next 256 bits
    task automatic grab(input int flip_at);
        logic prev;
        bit   found;
        prev  = 1'b1;
        found = 1'b0;
        while (!found) begin
            @(negedge clk);
            if (sync && !prev) found = 1'b1;
            prev = sync;
        end
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            cap[255-i] = sdata;
            capsync[i] = sync;
            if (i == flip_at) sq = ~sq;
        end
    endtask

    task automatic check_frame(input logic esq, input logic eav, input logic edv,
                               input logic [19:0] eaw, input logic [19:0] edw);
        logic [15:0]  etag;
        logic [255:0] esync;
        logic [19:0]  epcm;
        etag = {1'b1, eav, edv, 2'b11, 11'b0};
        epcm = esq ? PCM_HI : PCM_LO;
        for (int i = 0; i < 256; i++) esync[i] = (i < 15) || (i == 255);
        chk("R4 tag",               160'(cap[255:240]), 160'(etag));
        chk("R5 R2 slot1",          160'(cap[239:220]), 160'(eav ? eaw : 20'h0));
        chk("R5 R2 slot2",          160'(cap[219:200]), 160'(edv ? edw : 20'h0));
        chk("R6 left",              160'(cap[199:180]), 160'(epcm));
        chk("R6 right",             160'(cap[179:160]), 160'(epcm));
        chk("R7 pad",               cap[159:0],         160'h0);
        chk("R3 strobe pattern",    160'(capsync[159:0]), esync[159:0]);
        chk("R3 strobe pattern hi", 160'(capsync[255:160]), 160'(esync[255:160]));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        int gap;
        logic prev;
        // R9: defined outputs before the first edge
        #5;
        chk("R9 strobe at start", 160'(sync),  160'(1));
        chk("R9 data at start",   160'(sdata), 160'(0));

        // Table of vectors
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            sq = VEC[v].sq; av = VEC[v].av; dv = VEC[v].dv;
            aw = VEC[v].aw; dw = VEC[v].dw;
            grab(-1);
            check_frame(VEC[v].sq, VEC[v].av, VEC[v].dv, VEC[v].aw, VEC[v].dw);
        end

        // R1: rise-to-rise spacing
        prev = 1'b1;
        gap  = 0;
        while (!(sync && !prev)) begin
            prev = sync;
            @(negedge clk);
        end
        prev = sync;
        @(negedge clk);
        gap = 1;
        while (!(sync && !prev)) begin
            prev = sync;
            @(negedge clk);
            gap++;
        end
        chk("R1 frame period", 160'(gap), 160'(256));

        // R8: square-wave flip at frame bit 20 leaves the current frame untouched
        @(negedge clk);
        sq = 1'b0; av = 1'b1; dv = 1'b1; aw = 20'h18000; dw = 20'h08080;
        grab(20);
        chk("R8 left keeps old level",  160'(cap[199:180]), 160'(PCM_LO));
        chk("R8 right keeps old level", 160'(cap[179:160]), 160'(PCM_LO));
        grab(-1);
        chk("R8 new level next frame",  160'(cap[199:180]), 160'(PCM_HI));
        check_frame(1'b1, 1'b1, 1'b1, 20'h18000, 20'h08080);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule